// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

After each bus transaction a host controller has to rewrite the status byte of the transfer descriptor it just serviced. This block takes that byte and everything needed to update it: the descriptor's 2-bit retry counter, the endpoint's speed class, the transfer direction, whether the endpoint sits in the periodic schedule, and a one-hot code for how the transaction ended. It returns the new status byte, the new retry counter, a halt flag and a force-timeout request. All outputs are registered and come with a valid strobe.

The updater keeps the error flags sticky. When a fatal error occurs it halts the descriptor and clears its active bit in the same update. It also keeps two protocol state bits: one chooses between a start-split and a complete-split for full- and low-speed endpoints, and the other chooses between OUT and PING for high-speed OUT endpoints. For endpoints that are not high-speed, that second bit instead records an ERR handshake. The surrounding schedule engine writes the results back to descriptor memory. The block itself only computes them.

Top module: `td_status_update`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `out_valid`, `out_status`, `out_errcnt`, `out_halt` and `out_force_tmo` to 0.
- R2: Results appear one clock after the sampled `upd_valid`, with `out_valid` high for exactly that cycle. Cycles without `upd_valid` leave `out_status` and `out_errcnt` unchanged.
- R3: Status bit 7 means active. An update changes nothing (status and counter copied through, `out_halt` and `out_force_tmo` at 0) if bit 7 of `cur_status` is 0, or if `outcome` does not have exactly one bit set. The outcome bits are: 0 ACK, 1 NAK, 2 NYET, 3 STALL, 4 babble, 5 overrun, 6 underrun, 7 transaction error, 8 missed micro-frame, 9 ERR handshake.
- R4: Babble sets status bit 4 and halted bit 6, clears active bit 7, and raises `out_halt`.
- R5: STALL sets bit 6, clears bit 7, raises `out_halt`, and leaves bit 4 as it was.
- R6: Overrun or underrun sets the data buffer error bit 5 and does not halt. Overrun also raises `out_force_tmo` for that result.
- R7: A transaction error sets bit 3. A nonzero counter is decremented. A decrement to 0 halts the descriptor (bit 6 set, bit 7 cleared, `out_halt` high). A counter of 0 on entry stays 0 and causes no halt.
- R8: Missed micro-frame sets bit 2 only when `ep_speed` is not high speed (2'b10 is high speed; 2'b00, 2'b01 and 2'b11 are not) and `periodic` is 1. Otherwise the status is unchanged.
- R9: For endpoints that are not high-speed, ACK toggles split bit 1: 0 (start-split) becomes 1, and 1 (complete-split) becomes 0. For high-speed endpoints bit 1 never changes.
- R10: On a high-speed OUT endpoint (`dir_out`=1), NAK or NYET sets bit 0 to 1 (PING next), and an ACK while bit 0 is 1 clears it. On a high-speed IN endpoint bit 0 never changes.
- R11: An ERR handshake sets bit 0 when the endpoint is not high-speed and `periodic` is 1. Otherwise it is ignored.
- R12: Bits 6 through 2 are sticky: any of them that is 1 in `cur_status` is 1 in `out_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Inputs below hold one transaction result |
| cur_status | input | 8 | Descriptor status byte before the update |
| cur_errcnt | input | CNT_W | Retry counter before the update |
| ep_speed | input | 2 | Endpoint speed class, 2'b10 = high speed |
| dir_out | input | 1 | 1 = OUT transfer, 0 = IN |
| periodic | input | 1 | Endpoint is in the periodic schedule |
| outcome | input | 10 | One-hot transaction outcome |
| out_valid | output | 1 | Registered results below are new |
| out_status | output | 8 | Updated status byte |
| out_errcnt | output | CNT_W | Updated retry counter |
| out_halt | output | 1 | This update halted the descriptor |
| out_force_tmo | output | 1 | Force a timeout on the bus (overrun) |

## Verification
Every result sits behind one register stage. Outputs for inputs driven after a falling edge are therefore due at the next falling edge, one full cycle later, and the bench samples all four results there in a single comparison. Inputs are only ever changed just after a falling edge, so each sampled value belongs to exactly one update. Random updates are mixed with directed ones: counter exhaustion at 1 versus the unlimited value 0, the split toggle in both directions, ping state on OUT versus IN, speed and schedule gating, and illegal outcome codes. A bench function predicts every case from the requirements alone.

// File: rtl/td_status_pkg.sv
// Package: shared status-bit positions, outcome codes and decoded event type
// for the transfer descriptor status updater.
// Assumes an 8-bit status byte; positions are fixed because downstream
// descriptor logic decodes them.
package td_status_pkg;

    localparam int ST_W     = 8;
    localparam int ST_ACT   = 7;
    localparam int ST_HALT  = 6;
    localparam int ST_DBE   = 5;
    localparam int ST_BAB   = 4;
    localparam int ST_XERR  = 3;
    localparam int ST_MISS  = 2;
    localparam int ST_SPLIT = 1;
    localparam int ST_PERR  = 0;

    localparam int OC_ACK   = 0;
    localparam int OC_NAK   = 1;
    localparam int OC_NYET  = 2;
    localparam int OC_STALL = 3;
    localparam int OC_BAB   = 4;
    localparam int OC_OVR   = 5;
    localparam int OC_UDR   = 6;
    localparam int OC_XERR  = 7;
    localparam int OC_MISS  = 8;
    localparam int OC_SERR  = 9;
    localparam int OUTC_W   = 10;

    localparam logic [1:0] SPD_HIGH = 2'b10;

    typedef struct packed {
        logic ack;
        logic nak;
        logic nyet;
        logic stall;
        logic babble;
        logic overrun;
        logic underrun;
        logic xerr;
        logic missed;
        logic split_err;
    } td_evt_t;

endpackage

// File: rtl/td_outcome_decode.sv
// Module: splits the one-hot outcome vector into named events and reports
// whether exactly one outcome bit is set.
// Assumes the outcome bit order defined in td_status_pkg.
module td_outcome_decode
    import td_status_pkg::*;
(
    input  logic [OUTC_W-1:0] outcome,
    output td_evt_t           evt,
    output logic              legal
);

    localparam int CW = $clog2(OUTC_W + 1);

    logic [CW-1:0] ones;

    // Population count of the outcome vector.
    always_comb begin
        ones = '0;
        for (int i = 0; i < OUTC_W; i++) begin
            ones = ones + CW'(outcome[i]);
        end
    end

    // Legal only if exactly one outcome is flagged.
    assign legal = (ones == CW'(1));

    // Map each outcome bit onto its named event.
    always_comb begin
        evt.ack       = outcome[OC_ACK];
        evt.nak       = outcome[OC_NAK];
        evt.nyet      = outcome[OC_NYET];
        evt.stall     = outcome[OC_STALL];
        evt.babble    = outcome[OC_BAB];
        evt.overrun   = outcome[OC_OVR];
        evt.underrun  = outcome[OC_UDR];
        evt.xerr      = outcome[OC_XERR];
        evt.missed    = outcome[OC_MISS];
        evt.split_err = outcome[OC_SERR];
    end

endmodule

// File: rtl/td_errcnt_step.sv
// Module: retry counter step. Decrements on an enabled error unless the
// counter is zero, which stands for unlimited retries.
// Assumes the caller gates en with a legal, active update.
module td_errcnt_step #(
    parameter int CNT_W = 2
) (
    input  logic             en,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_out,
    output logic             exhausted
);

    logic nonzero;

    // Zero on entry means "never count down".
    assign nonzero = |cnt_in;

    // Next counter value and the exhaustion flag that triggers halt.
    always_comb begin
        cnt_out   = cnt_in;
        exhausted = 1'b0;
        if (en && nonzero) begin
            cnt_out   = cnt_in - CNT_W'(1);
            exhausted = (cnt_in == CNT_W'(1));
        end
    end

endmodule

// File: rtl/td_status_next.sv
// Module: combinational next-state of the descriptor status byte.
// Assumes evt is one-hot whenever apply is high; with apply low the byte
// passes through untouched.
module td_status_next
    import td_status_pkg::*;
(
    input  logic            apply,
    input  td_evt_t         evt,
    input  logic [ST_W-1:0] st_in,
    input  logic [1:0]      ep_speed,
    input  logic            dir_out,
    input  logic            periodic,
    input  logic            cnt_exhausted,
    output logic [ST_W-1:0] st_out,
    output logic            halt,
    output logic            force_tmo
);

    logic is_hs;
    logic split_sched;
    logic fatal;

    // Speed class and split-scheduling qualifiers.
    assign is_hs       = (ep_speed == SPD_HIGH);
    assign split_sched = !is_hs && periodic;

    // Any of these ends the descriptor.
    assign fatal = apply && (evt.babble || evt.stall || cnt_exhausted);

    // Status byte update: sticky flags, protocol state bits, halt.
    always_comb begin
        st_out = st_in;
        if (apply) begin
            if (evt.babble) st_out[ST_BAB] = 1'b1;
            if (evt.overrun || evt.underrun) st_out[ST_DBE] = 1'b1;
            if (evt.xerr) st_out[ST_XERR] = 1'b1;
            if (evt.missed && split_sched) st_out[ST_MISS] = 1'b1;
            if (evt.split_err && split_sched) st_out[ST_PERR] = 1'b1;
            if (evt.ack) begin
                if (is_hs) begin
                    if (dir_out && st_in[ST_PERR]) st_out[ST_PERR] = 1'b0;
                end else begin
                    st_out[ST_SPLIT] = !st_in[ST_SPLIT];
                end
            end
            if ((evt.nak || evt.nyet) && is_hs && dir_out) st_out[ST_PERR] = 1'b1;
        end
        if (fatal) begin
            st_out[ST_HALT] = 1'b1;
            st_out[ST_ACT]  = 1'b0;
        end
    end

    // Side-band results for the bus and schedule engine.
    assign halt      = fatal;
    assign force_tmo = apply && evt.overrun;

endmodule

// File: rtl/td_status_update.sv
// Module: top of the descriptor status updater. Decodes the outcome, steps
// the retry counter, computes the new status byte and registers all results.
// Assumes one update per upd_valid pulse; results follow one clock later.
module td_status_update
    import td_status_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [ST_W-1:0]   cur_status,
    input  logic [CNT_W-1:0]  cur_errcnt,
    input  logic [1:0]        ep_speed,
    input  logic              dir_out,
    input  logic              periodic,
    input  logic [OUTC_W-1:0] outcome,
    output logic              out_valid,
    output logic [ST_W-1:0]   out_status,
    output logic [CNT_W-1:0]  out_errcnt,
    output logic              out_halt,
    output logic              out_force_tmo
);

    td_evt_t          evt;
    logic             legal;
    logic             apply;
    logic [CNT_W-1:0] cnt_nxt;
    logic             exhausted;
    logic [ST_W-1:0]  st_nxt;
    logic             halt_nxt;
    logic             tmo_nxt;

    td_outcome_decode u_dec (
        .outcome (outcome),
        .evt     (evt),
        .legal   (legal)
    );

    // Only legal outcomes on active descriptors change anything.
    assign apply = legal && cur_status[ST_ACT];

    td_errcnt_step #(.CNT_W(CNT_W)) u_cnt (
        .en        (apply && evt.xerr),
        .cnt_in    (cur_errcnt),
        .cnt_out   (cnt_nxt),
        .exhausted (exhausted)
    );

    td_status_next u_next (
        .apply         (apply),
        .evt           (evt),
        .st_in         (cur_status),
        .ep_speed      (ep_speed),
        .dir_out       (dir_out),
        .periodic      (periodic),
        .cnt_exhausted (exhausted),
        .st_out        (st_nxt),
        .halt          (halt_nxt),
        .force_tmo     (tmo_nxt)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_status    <= '0;
            out_errcnt    <= '0;
            out_halt      <= 1'b0;
            out_force_tmo <= 1'b0;
        end else begin
            out_valid <= upd_valid;
            if (upd_valid) begin
                out_status    <= st_nxt;
                out_errcnt    <= cnt_nxt;
                out_halt      <= halt_nxt;
                out_force_tmo <= tmo_nxt;
            end else begin
                out_halt      <= 1'b0;
                out_force_tmo <= 1'b0;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(out_status) && $stable(out_errcnt)); // R2
    AST_HALT_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_halt |-> out_status[ST_HALT] && !out_status[ST_ACT]); // R4
    AST_TMO_WITH_DBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_force_tmo |-> out_status[ST_DBE] && !out_halt); // R6
    AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> out_errcnt <= $past(cur_errcnt)); // R7
    AST_HS_SPLIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && (ep_speed == SPD_HIGH) |=> out_status[ST_SPLIT] == $past(cur_status[ST_SPLIT])); // R9
    AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (out_status[6:2] & $past(cur_status[6:2])) == $past(cur_status[6:2])); // R12
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_halt && !out_force_tmo); // R3

endmodule

// File: tb/td_status_update_tb.sv
module td_status_update_tb;
    import td_status_pkg::*;

    localparam int CNT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_valid = 1'b0;
    logic [7:0]        cur_status = '0;
    logic [CNT_W-1:0]  cur_errcnt = '0;
    logic [1:0]        ep_speed = '0;
    logic              dir_out = 1'b0;
    logic              periodic = 1'b0;
    logic [OUTC_W-1:0] outcome = '0;
    logic              out_valid;
    logic [7:0]        out_status;
    logic [CNT_W-1:0]  out_errcnt;
    logic              out_halt;
    logic              out_force_tmo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    td_status_update #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid),
        .cur_status(cur_status), .cur_errcnt(cur_errcnt),
        .ep_speed(ep_speed), .dir_out(dir_out), .periodic(periodic),
        .outcome(outcome), .out_valid(out_valid), .out_status(out_status),
        .out_errcnt(out_errcnt), .out_halt(out_halt),
        .out_force_tmo(out_force_tmo)
    );

    // Expected {force, halt, errcnt, status} from the requirement text.
    function automatic logic [11:0] model(input logic [7:0] s, input logic [1:0] c,
                                          input logic [1:0] spd, input logic o,
                                          input logic per, input logic [9:0] oc);
        logic [7:0] n = s;
        logic [1:0] nc = c;
        logic h = 0, f = 0;
        logic hs = (spd == 2'b10);
        if (!s[7] || $countones(oc) != 1) return {1'b0, 1'b0, c, s};
        case (1'b1)
            oc[4]: begin n[4] = 1; h = 1; end
            oc[3]: h = 1;
            oc[5]: begin n[5] = 1; f = 1; end
            oc[6]: n[5] = 1;
            oc[7]: begin
                n[3] = 1;
                if (c != 0) begin nc = c - 1; if (c == 1) h = 1; end
            end
            oc[8]: if (!hs && per) n[2] = 1;
            oc[9]: if (!hs && per) n[0] = 1;
            oc[0]: if (!hs) n[1] = ~s[1]; else if (o) n[0] = 0;
            default: if (hs && o) n[0] = 1; // NAK / NYET
        endcase
        if (h) begin n[6] = 1; n[7] = 0; end
        return {f, h, nc, n};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one update after a falling edge, sample one cycle later.
    task automatic upd(input string req, input logic [7:0] s, input logic [1:0] c,
                       input logic [1:0] spd, input logic o, input logic per,
                       input logic [9:0] oc);
        logic [11:0] exp;
        cur_status = s; cur_errcnt = c; ep_speed = spd; dir_out = o;
        periodic = per; outcome = oc; upd_valid = 1'b1;
        exp = model(s, c, spd, o, per, oc);
        @(negedge clk);
        upd_valid = 1'b0;
        check(req, {out_force_tmo, out_halt, out_errcnt, out_status}, exp);
        check({req, "/valid"}, {11'd0, out_valid}, 12'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1", {out_force_tmo, out_halt, out_errcnt, out_status, out_valid}, 13'd0);
        rst_n = 1'b1;

        upd("R4", 8'h80, 2'd3, 2'b00, 1, 0, 10'h010);
        upd("R5", 8'h80, 2'd2, 2'b10, 0, 0, 10'h008);
        upd("R6", 8'h80, 2'd2, 2'b10, 1, 0, 10'h020);
        upd("R6", 8'h80, 2'd2, 2'b10, 1, 0, 10'h040);
        upd("R7", 8'h80, 2'd2, 2'b00, 0, 0, 10'h080);
        upd("R7", 8'h80, 2'd1, 2'b00, 0, 0, 10'h080);
        upd("R7", 8'h88, 2'd0, 2'b00, 0, 0, 10'h080);
        upd("R8", 8'h80, 2'd1, 2'b01, 0, 1, 10'h100);
        upd("R8", 8'h80, 2'd1, 2'b10, 0, 1, 10'h100);
        upd("R8", 8'h80, 2'd1, 2'b00, 0, 0, 10'h100);
        upd("R9", 8'h80, 2'd1, 2'b00, 0, 0, 10'h001);
        upd("R9", 8'h82, 2'd1, 2'b01, 0, 0, 10'h001);
        upd("R9", 8'h80, 2'd1, 2'b10, 0, 0, 10'h001);
        upd("R10", 8'h80, 2'd1, 2'b10, 1, 0, 10'h004);
        upd("R10", 8'h80, 2'd1, 2'b10, 1, 0, 10'h002);
        upd("R10", 8'h81, 2'd1, 2'b10, 1, 0, 10'h001);
        upd("R10", 8'h80, 2'd1, 2'b10, 0, 0, 10'h002);
        upd("R11", 8'h80, 2'd1, 2'b00, 0, 1, 10'h200);
        upd("R11", 8'h80, 2'd1, 2'b00, 0, 0, 10'h200);
        upd("R3", 8'h00, 2'd1, 2'b00, 0, 0, 10'h010);
        upd("R3", 8'h80, 2'd1, 2'b00, 0, 0, 10'h000);
        upd("R3", 8'h80, 2'd1, 2'b00, 0, 0, 10'h030);
        upd("R12", 8'hBC, 2'd1, 2'b00, 0, 1, 10'h001);

        held = {out_force_tmo, out_halt, out_errcnt, out_status};
        cur_status = 8'hFF; outcome = 10'h010;
        @(negedge clk);
        check("R2", {1'b0, 1'b0, out_errcnt, out_status, out_valid},
              {1'b0, 1'b0, held[9:0], 1'b0});

        for (int i = 0; i < 400; i++) begin
            logic [9:0] oc;
            logic [7:0] s;
            int k = $urandom_range(0, 19);
            s = 8'($urandom);
            if ($urandom_range(0, 4) != 0) s[7] = 1'b1;
            if (k < 10) oc = 10'd1 << k;
            else if (k < 12) oc = '0;
            else if (k < 14) oc = 10'(3) << $urandom_range(0, 8);
            else oc = 10'd1 << $urandom_range(0, 9);
            upd("R12", s, 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), oc);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule